// File: doc/BRIEF.md
# Backplane Slave Address Select and Wait-State Generator

This block decodes the address and status lines of a parallel backplane bus for one plug-in card. It produces two kinds of select. The first is a memory chip-select for a 4 KiB window. The second is a set of sixteen per-register strobes for a window of sixteen I/O ports. Static configuration inputs, which stand in for board switches, set where each window sits. They also set whether the 24-bit extended page takes part in the memory compare, how memory reacts to the phantom line, and whether memory answers at all.

For every access that selects the card, the block asks the bus master to stretch the cycle. It holds a not-ready request for a programmed number of bus clocks: 1, 2, 4 or 8. The request starts in the first clock of the access. It never appears for an access that selects nothing. The selects are purely combinational. The wait count lives in a small counter that is cleared whenever the bus cycle ends.

Top module: `busSlaveSelect`

## Requirements
- R1: `memSel` is 1 when `memRead` or `memWrite` is 1 and `addr[15:12]` equals `memBase`. It is 0 for any address outside that 4 KiB window.
- R2: With `extEn` = 1, memory additionally requires `addr[23:16]` to equal `extPage`. With `extEn` = 0, `addr[23:16]` has no effect on `memSel`.
- R3: With `phantomPol` = 0, memory answers only while `phantomN` = 1. With `phantomPol` = 1, memory answers only while `phantomN` = 0.
- R4: `memDisable` = 1 forces `memSel` to 0 whatever the address and status.
- R5: When `ioIn` or `ioOut` is 1 and `addr[7:4]` equals `ioBase`, exactly one bit of `ioStrobe` is 1. That bit is the one whose index is `addr[3:0]`. Outside the port window `ioStrobe` is all zero.
- R6: The selects follow address and status in the same clock with no register. With no status line asserted, no select is active.
- R7: A bus cycle begins in the first clock in which `cycleValid` is 1 after a clock in which it was 0. If that cycle selects memory or I/O, `holdReady` is 1 for exactly 1, 2, 4 or 8 clocks, for `waitCode` 0, 1, 2 or 3. The count starts with that first clock, and `holdReady` then stays 0 until the cycle ends.
- R8: `holdReady` is never 1 during an access that selects neither memory nor I/O.
- R9: When `cycleValid` falls before the count is used up, `holdReady` drops at once and the count is discarded. The next selected cycle reloads the full count.
- R10: With no cycle in progress, `holdReady` is 0 during and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 24 | Bus address; bits 23:16 are the extended page |
| memRead | input | 1 | Memory read status |
| memWrite | input | 1 | Memory write status |
| ioIn | input | 1 | I/O input status |
| ioOut | input | 1 | I/O output status |
| phantomN | input | 1 | Phantom line, active low |
| cycleValid | input | 1 | High while a bus cycle is in progress |
| memBase | input | 4 | Memory window position (address bits 15:12) |
| extEn | input | 1 | Include the extended page in the memory compare |
| extPage | input | 8 | Extended page value for the memory window |
| phantomPol | input | 1 | 0: memory hides under phantom; 1: memory appears only under phantom |
| memDisable | input | 1 | Suppress the memory select |
| ioBase | input | 4 | I/O window position (port bits 7:4) |
| waitCode | input | 2 | Wait length code: 1, 2, 4 or 8 clocks |
| memSel | output | 1 | Memory chip-select |
| ioStrobe | output | 16 | Per-port register strobes |
| holdReady | output | 1 | 1 = pull the bus ready line to not-ready |

## Verification
Some properties are checked by assertions on every clock:
- a cycle never asks for wait states unless something is selected;
- the wait request is contiguous from the start of a cycle;
- the counter reloads to the coded length and falls idle when a cycle ends;
- memory stays silent while disabled, and a strobe fires only inside the port window.

Other behaviour only the bench scenarios can show: the exact window edges, the two phantom polarities, the optional extended-page compare, and the precise number of wait clocks for each of the four codes. The bench also checks that an early cycle end followed by a fresh cycle loads the full count again.

// File: rtl/busSelPkg.sv
package busSelPkg;

  // Strobes sent from the wait control to the wait-count datapath.
  typedef struct packed {
    logic load;   // start of a selected cycle: load the coded length
    logic clear;  // bus cycle over: discard any remaining count
    logic dec;    // one wait clock consumed
  } waitCmd_t;

endpackage

// File: rtl/addrDecode.sv
module addrDecode #(
  parameter int ADDR_W      = 24,
  parameter int LOCAL_W     = 16,
  parameter int MEM_WIN_W   = 12,
  parameter int IO_ADDR_W   = 8,
  parameter int IO_WIN_W    = 4,
  localparam int EXT_W      = ADDR_W - LOCAL_W,
  localparam int MEM_BASE_W = LOCAL_W - MEM_WIN_W,
  localparam int IO_BASE_W  = IO_ADDR_W - IO_WIN_W,
  localparam int IO_PORTS   = 1 << IO_WIN_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  memRead,
  input  logic                  memWrite,
  input  logic                  ioIn,
  input  logic                  ioOut,
  input  logic                  phantomN,
  input  logic [MEM_BASE_W-1:0] memBase,
  input  logic                  extEn,
  input  logic [EXT_W-1:0]      extPage,
  input  logic                  phantomPol,
  input  logic                  memDisable,
  input  logic [IO_BASE_W-1:0]  ioBase,
  output logic                  memSel,
  output logic [IO_PORTS-1:0]   ioStrobe
);

  logic memCycle, ioCycle;
  logic pageMatch, extMatch, phantomOk, ioHit;
  logic unusedIoBits;

  assign memCycle  = memRead | memWrite;
  assign ioCycle   = ioIn | ioOut;

  assign pageMatch = (addr[LOCAL_W-1:MEM_WIN_W] == memBase);
  assign extMatch  = ~extEn | (addr[ADDR_W-1:LOCAL_W] == extPage);
  // phantomPol=1: present only while phantom is asserted (low).
  assign phantomOk = phantomPol ? ~phantomN : phantomN;

  assign memSel = memCycle & ~memDisable & pageMatch & extMatch & phantomOk;

  assign ioHit = ioCycle & (addr[IO_ADDR_W-1:IO_WIN_W] == ioBase);

  generate
    for (genvar p = 0; p < IO_PORTS; p++) begin : g_strobe
      assign ioStrobe[p] = ioHit & (addr[IO_WIN_W-1:0] == IO_WIN_W'(p));
    end
  endgenerate

  // I/O ports use an 8-bit address; bits between it and the memory page are not decoded.
  assign unusedIoBits = ^addr[MEM_WIN_W-1:IO_ADDR_W];

  // R4
  mem_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDisable |-> !memSel);

  // R5
  io_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ioStrobe) |-> ((addr[IO_ADDR_W-1:IO_WIN_W] == ioBase) && (ioIn || ioOut)));

  // R6
  mem_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    memSel |-> (memRead || memWrite));

endmodule

// File: rtl/waitCtrl.sv
module waitCtrl
  import busSelPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cycleValid,
  input  logic     anyHit,
  input  logic     cntBusy,
  output waitCmd_t cmd,
  output logic     holdReady
);

  logic prevValid;
  logic cycleStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevValid <= 1'b0;
    else       prevValid <= cycleValid;
  end

  assign cycleStart = cycleValid & ~prevValid;

  always_comb begin
    cmd.clear = ~cycleValid;
    cmd.load  = cycleStart & anyHit;
    cmd.dec   = cycleValid & ~cycleStart & cntBusy;
  end

  // The first wait clock is covered combinationally; the counter covers the rest.
  assign holdReady = cycleValid & anyHit & (cycleStart | cntBusy);

  // R8
  no_wait_unselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdReady |-> anyHit);

  // R7
  wait_contiguous_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdReady && !cmd.load) |-> $past(holdReady));

  // R9
  end_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cycleValid |-> !holdReady);

endmodule

// File: rtl/waitCounter.sv
module waitCounter
  import busSelPkg::*;
#(
  parameter int WAIT_CODE_W = 2,
  localparam int NUM_CODES  = 1 << WAIT_CODE_W,
  localparam int MAX_WAIT   = 1 << (NUM_CODES - 1),
  localparam int CNT_W      = (MAX_WAIT > 2) ? $clog2(MAX_WAIT) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  waitCmd_t               cmd,
  input  logic [WAIT_CODE_W-1:0] waitCode,
  output logic                   cntBusy
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  // Code k gives 2**k wait clocks; the first is spent in the start clock.
  assign loadVal = (CNT_W'(1) << waitCode) - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (cmd.clear) cnt <= '0;
    else if (cmd.load)  cnt <= loadVal;
    else if (cmd.dec)   cnt <= cnt - CNT_W'(1);
  end

  assign cntBusy = (cnt != '0);

  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (cnt == $past(loadVal)));

  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> !cntBusy);

  // R7
  count_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/busSlaveSelect.sv
module busSlaveSelect
  import busSelPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LOCAL_W     = 16,
  parameter int MEM_WIN_W   = 12,
  parameter int IO_ADDR_W   = 8,
  parameter int IO_WIN_W    = 4,
  parameter int WAIT_CODE_W = 2,
  localparam int EXT_W      = ADDR_W - LOCAL_W,
  localparam int MEM_BASE_W = LOCAL_W - MEM_WIN_W,
  localparam int IO_BASE_W  = IO_ADDR_W - IO_WIN_W,
  localparam int IO_PORTS   = 1 << IO_WIN_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   memRead,
  input  logic                   memWrite,
  input  logic                   ioIn,
  input  logic                   ioOut,
  input  logic                   phantomN,
  input  logic                   cycleValid,
  input  logic [MEM_BASE_W-1:0]  memBase,
  input  logic                   extEn,
  input  logic [EXT_W-1:0]       extPage,
  input  logic                   phantomPol,
  input  logic                   memDisable,
  input  logic [IO_BASE_W-1:0]   ioBase,
  input  logic [WAIT_CODE_W-1:0] waitCode,
  output logic                   memSel,
  output logic [IO_PORTS-1:0]    ioStrobe,
  output logic                   holdReady
);

  waitCmd_t cmd;
  logic     cntBusy;
  logic     anyHit;

  addrDecode #(
    .ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W), .MEM_WIN_W(MEM_WIN_W),
    .IO_ADDR_W(IO_ADDR_W), .IO_WIN_W(IO_WIN_W)
  ) uDecode (
    .clk(clk), .rstN(rstN), .addr(addr),
    .memRead(memRead), .memWrite(memWrite), .ioIn(ioIn), .ioOut(ioOut),
    .phantomN(phantomN), .memBase(memBase), .extEn(extEn), .extPage(extPage),
    .phantomPol(phantomPol), .memDisable(memDisable), .ioBase(ioBase),
    .memSel(memSel), .ioStrobe(ioStrobe)
  );

  assign anyHit = memSel | (|ioStrobe);

  waitCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cycleValid(cycleValid), .anyHit(anyHit),
    .cntBusy(cntBusy), .cmd(cmd), .holdReady(holdReady)
  );

  waitCounter #(.WAIT_CODE_W(WAIT_CODE_W)) uCount (
    .clk(clk), .rstN(rstN), .cmd(cmd), .waitCode(waitCode), .cntBusy(cntBusy)
  );

endmodule

// File: tb/busSlaveSelect_test.sv
module busSlaveSelect_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [23:0] addr;
  logic        memRead, memWrite, ioIn, ioOut, phantomN, cycleValid;
  logic [3:0]  memBase;
  logic        extEn;
  logic [7:0]  extPage;
  logic        phantomPol, memDisable;
  logic [3:0]  ioBase;
  logic [1:0]  waitCode;
  logic        memSel;
  logic [15:0] ioStrobe;
  logic        holdReady;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  busSlaveSelect uut (
    .clk(clk), .rstN(rstN), .addr(addr), .memRead(memRead), .memWrite(memWrite),
    .ioIn(ioIn), .ioOut(ioOut), .phantomN(phantomN), .cycleValid(cycleValid),
    .memBase(memBase), .extEn(extEn), .extPage(extPage), .phantomPol(phantomPol),
    .memDisable(memDisable), .ioBase(ioBase), .waitCode(waitCode),
    .memSel(memSel), .ioStrobe(ioStrobe), .holdReady(holdReady)
  );

  typedef struct packed {
    logic [23:0] a;
    logic [3:0]  st;     // {memRead, memWrite, ioIn, ioOut}
    logic        phN;
    logic        xEn;
    logic        pol;
    logic        dis;
    logic        eMem;
    logic [15:0] eStrb;
  } vec_t;

  localparam int NV = 17;
  // memBase=A, extPage=3C, ioBase=5 throughout
  localparam vec_t VECS [NV] = '{
    '{24'h00A123, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000}, // R1 inside
    '{24'h00AFFF, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000}, // R1 top edge
    '{24'h00B000, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R1 above
    '{24'h009FFF, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R1 below
    '{24'h77A000, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000}, // R2 page ignored
    '{24'h77A000, 4'b1000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2 page mismatch
    '{24'h3CA010, 4'b1000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000}, // R2 page match
    '{24'h00A000, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3 hide
    '{24'h00A000, 4'b1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000}, // R3 appear
    '{24'h00A000, 4'b1000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000}, // R3 absent
    '{24'h00A000, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000}, // R4 disabled
    '{24'h000050, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001}, // R5 low port
    '{24'h00005F, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8000}, // R5 high port
    '{24'h000060, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R5 above
    '{24'h00004F, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R5 below
    '{24'h00A05A, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R6 no status
    '{24'h00A05A, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0400}  // R6 io only
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idleBus();
    {memRead, memWrite, ioIn, ioOut} = 4'b0000;
    cycleValid = 1'b0;
  endtask

  // Runs one bus cycle of 'len' clocks; expects holdReady for the first 'expN'.
  task automatic runWait(input string tag, input logic [1:0] code, input bit useIo,
                         input bit hit, input int len, input int expN);
    @(negedge clk);
    idleBus();
    @(negedge clk);
    waitCode = code;
    if (useIo) begin
      addr = hit ? 24'h000053 : 24'h000073;
      ioOut = 1'b1;
    end else begin
      addr = hit ? 24'h00A400 : 24'h00C400;
      memRead = 1'b1;
    end
    cycleValid = 1'b1;
    #1 check(tag, 32'(holdReady), 32'(expN > 0));
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      #1 check(tag, 32'(holdReady), 32'(k < expN));
    end
    @(negedge clk);
    idleBus();
    #1 check(tag, 32'(holdReady), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    addr = '0;
    idleBus();
    phantomN = 1'b1;
    memBase = 4'hA; extEn = 1'b0; extPage = 8'h3C;
    phantomPol = 1'b0; memDisable = 1'b0; ioBase = 4'h5; waitCode = 2'd0;

    // R10 reset state
    repeat (3) @(negedge clk);
    #1 check("R10 hold in reset", 32'(holdReady), 32'd0);
    check("R6 mem idle in reset", 32'(memSel), 32'd0);
    check("R6 strobes idle in reset", 32'(ioStrobe), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    #1 check("R10 hold after reset", 32'(holdReady), 32'd0);

    // Decode table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VECS[i].a;
      {memRead, memWrite, ioIn, ioOut} = VECS[i].st;
      phantomN = VECS[i].phN;
      extEn = VECS[i].xEn;
      phantomPol = VECS[i].pol;
      memDisable = VECS[i].dis;
      #1;
      check($sformatf("R1-table vec %0d memSel", i), 32'(memSel), 32'(VECS[i].eMem));
      check($sformatf("R5-table vec %0d ioStrobe", i), 32'(ioStrobe), 32'(VECS[i].eStrb));
    end
    @(negedge clk);
    idleBus();
    phantomN = 1'b1; extEn = 1'b0; phantomPol = 1'b0; memDisable = 1'b0;

    // R7 all four codes, memory and I/O
    runWait("R7 mem code0", 2'd0, 1'b0, 1'b1, 4, 1);
    runWait("R7 mem code1", 2'd1, 1'b0, 1'b1, 5, 2);
    runWait("R7 io code2", 2'd2, 1'b1, 1'b1, 7, 4);
    runWait("R7 mem code3", 2'd3, 1'b0, 1'b1, 11, 8);
    runWait("R7 io code3", 2'd3, 1'b1, 1'b1, 10, 8);

    // R8 unselected accesses never wait
    runWait("R8 mem miss", 2'd3, 1'b0, 1'b0, 6, 0);
    runWait("R8 io miss", 2'd2, 1'b1, 1'b0, 6, 0);

    // R9 early end, then a fresh cycle reloads
    runWait("R9 early end", 2'd3, 1'b0, 1'b1, 3, 8);
    runWait("R9 reload after early end", 2'd3, 1'b1, 1'b1, 9, 8);
    runWait("R9 reload short", 2'd1, 1'b0, 1'b1, 3, 2);

    // R4 disabled memory does not wait
    memDisable = 1'b1;
    runWait("R4 disabled no wait", 2'd2, 1'b0, 1'b1, 5, 0);
    memDisable = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule